// File: doc/BRIEF.md
# Flow-Through Burst SRAM With Zero Turnaround

A synchronous static memory model whose reads and writes may be mixed on every clock with no idle cycle between them. A read returns data in the same cycle as its registered address: there is no output register. A write takes its data one enabled clock after its address, so the bus holds write data in the very cycle that a read would have used for its output. This is why the direction of the bus can flip on every cycle.

The array is split into byte lanes of nine bits each, eight data bits plus one parity bit. Per-lane selects qualify each write. A short burst can be continued from any loaded address without presenting a new address. The burst walks the two low address bits in linear order or in interleaved order. A clock-enable input freezes every piece of state, and an asynchronous disable input takes the data outputs off the bus. The bidirectional data bus is modelled as separate in, out and output-enable signals.

Top module: `fts_sram`

## Requirements
- R1: While `rst_n` is low, `dq_oe` is 0, and the first enabled edge after reset that uses `adv`=1 continues a deselect.
- R2: At an edge where `clk_en` is 0, nothing changes. The address and burst state are held, no write is performed, and `dq_oe`/`dq_out` keep their values.
- R3: A read is loaded at enabled edge N when `adv`=0, the chip is selected and `wr`=0. During the cycle after edge N, `dq_oe`=1 and `dq_out` equals the stored word, with no further register stage.
- R4: A write is loaded at enabled edge N when `adv`=0, the chip is selected and `wr`=1. The value on `dq_in` at the next enabled edge is stored at the address registered at edge N.
- R5: `bsel[i]` registered with a write address enables bits [9i+8:9i] (a lane of 8 data bits plus its parity bit). Lanes whose select is 0 keep their old contents, and a write with `bsel`=0 stores nothing.
- R6: During the data phase of a write, `dq_oe` is 0.
- R7: Any mix of reads and writes runs at one transfer per enabled clock. A read of an address in the cycle after a write to it returns the new data.
- R8: A burst position counter is cleared on load and advances on each enabled `adv`=1 edge. The low two address bits are (base+count) mod 4 when `interleave`=0 at load, and base XOR count when `interleave`=1 at load. The upper address bits stay fixed.
- R9: An enabled edge with `adv`=1 repeats the type of the previous operation, whether read, write or deselect.
- R10: A load is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. Otherwise it is a deselect, and `dq_oe` is 0 in the following cycle.
- R11: `out_dis`=1 forces `dq_oe` to 0 at once, in any cycle. `dq_out` is 0 whenever `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset of control state |
| clk_en | input | 1 | 1 = edge takes effect, 0 = stall |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| wr | input | 1 | 1 = write, 0 = read on a load |
| adv | input | 1 | 1 = continue burst, 0 = load address |
| bsel | input | 4 | Per-lane write selects |
| interleave | input | 1 | Burst order on load: 1 = interleaved |
| addr | input | 8 | Word address |
| dq_in | input | 36 | Write data from bus |
| dq_out | output | 36 | Read data to bus |
| dq_oe | output | 1 | Bus drive enable |
| out_dis | input | 1 | Asynchronous output disable |

## Verification
A wrong operation type held in the control register shows up at once, on the cycle after the offending edge: `dq_oe` rises during a write data phase or stays low on a read. A wrong burst count or order shows up as read data from a neighbouring word within the same burst. A misrouted write data phase or a wrong lane select stays hidden until that word is read back. For this reason the bench pairs every write with later reads against its own copy of the array, and it prefills the array with address-tagged words so that any wrong address is visible.

// File: rtl/fts_sram_pkg.sv
package fts_sram_pkg;
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/fts_burst_seq.sv
module fts_burst_seq
    import fts_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [BURST_W-1:0] beat,
    input  logic               interleave,
    output logic [ADDR_W-1:0]  addr
);
    logic [BURST_W-1:0] low;

    // Only the low bits walk; the rest of the base is held for the burst.
    always_comb begin
        if (interleave) low = base[BURST_W-1:0] ^ beat;
        else            low = base[BURST_W-1:0] + beat;
        addr = {base[ADDR_W-1:BURST_W], low};
    end
endmodule

// File: rtl/fts_lane_bank.sv
module fts_lane_bank #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Flow-through: no output register.
    assign rdata = mem[raddr];
endmodule

// File: rtl/fts_sram.sv
module fts_sram
    import fts_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clk_en,
    input  logic                     cs1_n,
    input  logic                     cs2,
    input  logic                     cs3_n,
    input  logic                     wr,
    input  logic                     adv,
    input  logic [LANES-1:0]         bsel,
    input  logic                     interleave,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [LANES*LANE_W-1:0]  dq_in,
    output logic [LANES*LANE_W-1:0]  dq_out,
    output logic                     dq_oe,
    input  logic                     out_dis
);
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        op_e                op;
        logic [ADDR_W-1:0]  base;
        logic [BURST_W-1:0] beat;
        logic               ileave;
        logic [LANES-1:0]   bsel;
    } ctl_t;

    localparam ctl_t CTL_RST = '{op: OP_IDLE, base: '0, beat: '0, ileave: 1'b0, bsel: '0};

    ctl_t              ctl_d, ctl_q;
    logic              chip_sel;
    logic              wr_fire;
    logic [ADDR_W-1:0] cur_addr;
    logic [LANES-1:0]  lane_we;
    logic [DATA_W-1:0] rd_word;

    fts_burst_seq #(.ADDR_W(ADDR_W)) i_burst (
        .base       (ctl_q.base),
        .beat       (ctl_q.beat),
        .interleave (ctl_q.ileave),
        .addr       (cur_addr)
    );

    always_comb begin
        ctl_d    = ctl_q;
        chip_sel = !cs1_n && cs2 && !cs3_n;
        // Data phase of a pending write lands on this enabled edge.
        wr_fire  = clk_en && (ctl_q.op == OP_WRITE);
        lane_we  = wr_fire ? ctl_q.bsel : '0;
        if (clk_en) begin
            if (!adv) begin
                ctl_d.beat = '0;
                if (chip_sel) begin
                    ctl_d.op     = wr ? OP_WRITE : OP_READ;
                    ctl_d.base   = addr;
                    ctl_d.ileave = interleave;
                    ctl_d.bsel   = bsel;
                end else begin
                    ctl_d.op = OP_IDLE;
                end
            end else begin
                // Continue: same operation type, next beat.
                ctl_d.beat = ctl_q.beat + 1'b1;
                ctl_d.bsel = bsel;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fts_lane_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) i_bank (
            .clk   (clk),
            .we    (lane_we[g]),
            .waddr (cur_addr),
            .wdata (dq_in[g*LANE_W +: LANE_W]),
            .raddr (cur_addr),
            .rdata (rd_word[g*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        dq_oe  = (ctl_q.op == OP_READ) && !out_dis;
        dq_out = dq_oe ? rd_word : '0;
    end
endmodule

// File: rtl/fts_sram_chk.sv
module fts_sram_chk #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     clk_en,
    input logic                     cs1_n,
    input logic                     cs2,
    input logic                     cs3_n,
    input logic                     wr,
    input logic                     adv,
    input logic [LANES-1:0]         bsel,
    input logic                     interleave,
    input logic [ADDR_W-1:0]        addr,
    input logic [LANES*LANE_W-1:0]  dq_in,
    input logic [LANES*LANE_W-1:0]  dq_out,
    input logic                     dq_oe,
    input logic                     out_dis
);
    logic sel;
    assign sel = !cs1_n && cs2 && !cs3_n;

    // R6
    wr_phase_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv && sel && wr) |=> !dq_oe);

    // R10
    desel_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv && !sel) |=> !dq_oe);

    // R3
    rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv && sel && !wr) |=> (dq_oe || out_dis));

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && !out_dis) |=> (out_dis || ($stable(dq_oe) && $stable(dq_out))));

    // R11
    dis_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_dis |-> !dq_oe);

    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq_out == '0));
endmodule

bind fts_sram fts_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_chk (.*);

// File: tb/test_fts_sram.sv
module test_fts_sram;
    localparam int AW = 8;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_en = 1'b1, cs1_n = 1'b0, cs2 = 1'b1, cs3_n = 1'b0;
    logic wr = 1'b0, adv = 1'b1, interleave = 1'b0, out_dis = 1'b0;
    logic [NL-1:0] bsel = '0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic dq_oe;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic [DW-1:0] ref_mem [1 << AW];
    int            m_op = 0;          // 0 idle, 1 read, 2 write
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = '0;
    logic          m_il = 1'b0;
    logic [NL-1:0] m_bsel = '0;

    always #5 clk = ~clk;

    fts_sram i_fts_sram (.*);

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return {4'h5, a, ~a, a, a};
    endfunction

    function automatic logic [AW-1:0] m_addr();
        logic [1:0] lo;
        lo = m_il ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        logic [AW-1:0] a;
        if (!clk_en) return;
        if (m_op == 2) begin
            a = m_addr();
            for (int i = 0; i < NL; i++)
                if (m_bsel[i]) ref_mem[a][i*LW +: LW] = dq_in[i*LW +: LW];
        end
        if (!adv) begin
            m_beat = '0;
            if (!cs1_n && cs2 && !cs3_n) begin
                m_op = wr ? 2 : 1; m_base = addr; m_il = interleave; m_bsel = bsel;
            end else m_op = 0;
        end else begin
            m_beat = m_beat + 2'd1;
            m_bsel = bsel;
        end
    endtask

    task automatic check_out();
        bit eoe;
        logic [DW-1:0] ed;
        eoe = (m_op == 1) && !out_dis;
        ed  = eoe ? ref_mem[m_addr()] : '0;
        chk(dq_oe == eoe, (m_op == 2) ? "R6 oe" : (m_op == 1 ? "R3 oe" : "R10 oe"), DW'(dq_oe), DW'(eoe));
        chk(dq_out == ed, eoe ? "R3 data" : "R11 idle data", dq_out, ed);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_out();
    endtask

    task automatic load(input bit w, input logic [AW-1:0] a, input logic [NL-1:0] bs, input bit il);
        clk_en = 1; adv = 0; cs1_n = 0; cs2 = 1; cs3_n = 0; wr = w; addr = a; bsel = bs; interleave = il;
        step();
    endtask

    task automatic cont();
        clk_en = 1; adv = 1;
        step();
    endtask

    task automatic desel();
        clk_en = 1; adv = 0; cs2 = 0;
        step();
        cs2 = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(dq_oe == 1'b0, "R1 oe in reset", DW'(dq_oe), '0);
        rst_n = 1'b1;
        cont();
        chk(dq_oe == 1'b0, "R1 continue after reset", DW'(dq_oe), '0);

        // Prefill with address tags, one write per clock (R4, R7)
        for (int a = 0; a < (1 << AW); a++) begin
            dq_in = pat(AW'(a - 1));
            load(1'b1, AW'(a), '1, 1'b0);
        end
        dq_in = pat(AW'((1 << AW) - 1));
        desel();

        // R8 linear order from low bits 01: 41,42,43,40
        load(1'b0, 8'h41, '0, 1'b0);
        chk(dq_out == pat(8'h41), "R8 lin beat0", dq_out, pat(8'h41));
        cont(); chk(dq_out == pat(8'h42), "R8 lin beat1", dq_out, pat(8'h42));
        cont(); chk(dq_out == pat(8'h43), "R8 lin beat2", dq_out, pat(8'h43));
        cont(); chk(dq_out == pat(8'h40), "R8 lin wrap", dq_out, pat(8'h40));
        // R8 interleaved order: 41,40,43,42 (R9 continue repeats read)
        load(1'b0, 8'h41, '0, 1'b1);
        cont(); chk(dq_out == pat(8'h40), "R8 il beat1", dq_out, pat(8'h40));
        cont(); chk(dq_out == pat(8'h43), "R8 il beat2", dq_out, pat(8'h43));
        cont(); chk(dq_out == pat(8'h42), "R9 R8 il beat3", dq_out, pat(8'h42));

        // R2 stall mid-burst
        load(1'b0, 8'h80, '0, 1'b0);
        clk_en = 0; adv = 0; addr = 8'h00; step();
        chk(dq_out == pat(8'h80) && dq_oe, "R2 stall holds read", dq_out, pat(8'h80));
        cont(); chk(dq_out == pat(8'h81), "R2 burst resumes", dq_out, pat(8'h81));

        // R2 stall in write data phase: junk must not be written
        load(1'b1, 8'h10, '1, 1'b0);
        dq_in = '1; clk_en = 0; step();
        dq_in = 36'h123456789; desel();
        load(1'b0, 8'h10, '0, 1'b0);
        chk(dq_out == 36'h123456789, "R2 R4 write after stall", dq_out, 36'h123456789);

        // R5 partial lanes 0 and 2, then no lanes
        load(1'b1, 8'h20, 4'b0101, 1'b0);
        dq_in = '1; load(1'b1, 8'h21, 4'b0000, 1'b0);
        dq_in = '1; desel();
        load(1'b0, 8'h20, '0, 1'b0);
        chk(dq_out == {pat(8'h20)[35:27], 9'h1FF, pat(8'h20)[17:9], 9'h1FF}, "R5 partial lanes",
            dq_out, {pat(8'h20)[35:27], 9'h1FF, pat(8'h20)[17:9], 9'h1FF});
        load(1'b0, 8'h21, '0, 1'b0);
        chk(dq_out == pat(8'h21), "R5 no lanes", dq_out, pat(8'h21));

        // R7 write, read same word next cycle, repeated
        load(1'b1, 8'h30, '1, 1'b0);
        dq_in = 36'hABCDE0123; load(1'b0, 8'h30, '0, 1'b0);
        chk(dq_out == 36'hABCDE0123, "R7 read after write", dq_out, 36'hABCDE0123);
        load(1'b1, 8'h31, '1, 1'b0);
        chk(dq_oe == 1'b0, "R6 data phase", DW'(dq_oe), '0);
        dq_in = 36'h0F0F0F0F0; load(1'b0, 8'h31, '0, 1'b0);
        chk(dq_out == 36'h0F0F0F0F0, "R7 second turn", dq_out, 36'h0F0F0F0F0);

        // R10 each enable alone deselects; R9 continue keeps deselect
        cs1_n = 1; clk_en = 1; adv = 0; wr = 0; step(); cs1_n = 0;
        chk(dq_oe == 1'b0, "R10 cs1_n high", DW'(dq_oe), '0);
        adv = 0; cs3_n = 1; step(); cs3_n = 0;
        chk(dq_oe == 1'b0, "R10 cs3_n high", DW'(dq_oe), '0);
        desel();
        chk(dq_oe == 1'b0, "R10 cs2 low", DW'(dq_oe), '0);
        cont();
        chk(dq_oe == 1'b0, "R9 continue deselect", DW'(dq_oe), '0);

        // R9 continued write stores to next beat
        load(1'b1, 8'h50, '1, 1'b0);
        dq_in = 36'h111111111; cont();
        dq_in = 36'h222222222; desel();
        load(1'b0, 8'h51, '0, 1'b0);
        chk(dq_out == 36'h222222222, "R9 continue write", dq_out, 36'h222222222);

        // R11 asynchronous disable while reading
        out_dis = 1; #1;
        chk(dq_oe == 1'b0 && dq_out == '0, "R11 disable", dq_out, '0);
        out_dis = 0; #1;
        chk(dq_oe == 1'b1 && dq_out == 36'h222222222, "R11 release", dq_out, 36'h222222222);

        // Random mixed traffic against the model
        for (int n = 0; n < 4000; n++) begin
            clk_en     = ($urandom % 10) != 0;
            adv        = ($urandom % 5) < 2;
            cs1_n      = ($urandom % 12) == 0;
            cs2        = ($urandom % 12) != 0;
            cs3_n      = ($urandom % 12) == 0;
            wr         = $urandom % 2;
            bsel       = NL'($urandom);
            interleave = $urandom % 2;
            addr       = AW'($urandom);
            dq_in      = {4'($urandom), 32'($urandom)};
            out_dis    = ($urandom % 20) == 0;
            step();
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule